// File: doc/BRIEF.md
# Tile Scanline Renderer

This block is the per-line drawing engine of a tile-based display processor. A dot counter and a line counter walk each frame through a fixed sequence. Every visible line opens with an object-search window. A pixel-transfer window follows, then a horizontal-blank gap fills the rest of the line. Once the last visible line is done, blank lines run until the frame wraps. The current phase is published as a two-bit mode so that the processor side knows when video memory is free.

During pixel transfer a fetcher reads the background map entry for the next tile column. It then reads the two bitplane bytes of the tile row that the scrolled line falls on, and pushes all eight 2-bit pixels into a 16-entry FIFO in one step. The FIFO feeds the display one pixel per dot, but only while it holds more than eight pixels. The first few pixels of every line are dropped to give fine horizontal scroll. Video memory is modelled as an 8 KiB space with 13-bit addresses, and its read data is expected in the same dot as the address.

Top module: `tile_scan_renderer`

## Requirements
- R1: The mode output uses 0 for horizontal blank, 1 for vertical blank, 2 for object search and 3 for pixel transfer. A visible line is in mode 2 for dots 0 to SEARCH_DOTS-1 and enters mode 3 at dot SEARCH_DOTS. Once its last pixel has been emitted it stays in mode 0 up to dot LINE_DOTS-1.
- R2: The line output counts up by one when the dot counter wraps from LINE_DOTS-1, and returns to 0 after FRAME_LINES-1. Lines VIS_H and above are in mode 1 for the whole line.
- R3: Each visible line produces exactly VIS_W cycles with pix_valid high. Blank lines produce none.
- R4: A pixel at column c (0 = leftmost) of a tile row is {high byte bit 7-c, low byte bit 7-c}. The low byte sits at the even row address and the high byte at the next address.
- R5: The map entry for a fetch is read at base + 32*(((line+scy) mod 256)/8) + ((scx/8 + fetch column) mod 32). The base is 0x1800 when map_hi is 0 and 0x1C00 when it is 1.
- R6: The tile row address is idx*16 + 2*((line+scy) mod 8) when tile_unsigned is 1. When it is 0, idx is taken as signed and the address is 0x1000 + idx*16 + 2*((line+scy) mod 8).
- R7: The first (scx mod 8) pixels taken from the FIFO on each line are dropped. The first valid pixel appears at dot SEARCH_DOTS+15+(scx mod 8).
- R8: Each of the three fetch reads holds its address for two dots. A push of eight pixels happens only when the FIFO holds at most 8, a pop only when it holds more than 8, never both in one dot, and the fill never exceeds 16.
- R9: vram_rd is high only in mode 3.
- R10: While rst_n is low, mode is 2, line is 0, and pix_valid and vram_rd are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scx | input | 8 | Horizontal scroll in pixels |
| scy | input | 8 | Vertical scroll in lines |
| map_hi | input | 1 | Selects the upper background map |
| tile_unsigned | input | 1 | 1: unsigned tile index from 0x0000; 0: signed index around 0x1000 |
| vram_rdata | input | 8 | Video memory read data for the current address |
| vram_addr | output | 13 | Video memory read address |
| vram_rd | output | 1 | Read in progress |
| pix_data | output | 2 | Pixel value |
| pix_valid | output | 1 | pix_data carries a displayed pixel |
| line | output | 8 | Current line number |
| mode | output | 2 | Current scanline phase |

## Verification
The bench fills video memory with random bytes, so map entries and bitplanes differ at almost every address. Every displayed pixel is compared against a model that works from the scrolled screen position rather than from fetch columns. Zero scroll shows the basic path. A scroll of 7 shows the drop count and the first-pixel dot. A scroll of 255 and a vertical scroll near 256 show wrap-around in both directions. The two map bases and the two tile-index modes show address forming, with the signed mode hitting indices on both sides of 128. The remaining frames use random settings to mix these cases.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int ROW_PX     = 8;
  localparam int FIFO_DEPTH = 2 * ROW_PX;
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);

  typedef enum logic [1:0] {
    MODE_HBLANK = 2'd0,
    MODE_VBLANK = 2'd1,
    MODE_SEARCH = 2'd2,
    MODE_XFER   = 2'd3
  } mode_t;

  typedef enum logic [2:0] {
    FS_IDX0, FS_IDX1, FS_LO0, FS_LO1, FS_HI0, FS_HI1, FS_PUSH
  } fstate_t;

  typedef logic [ROW_PX-1:0][1:0] row_t;

  // Map entry address: two map bases, 32x32 entries each.
  function automatic logic [12:0] map_addr(input logic map_hi, input logic [7:0] ly,
                                           input logic [7:0] scy, input logic [7:0] scx,
                                           input logic [4:0] fcol);
    logic [7:0] y;
    logic [4:0] col;
    y   = ly + scy;
    col = scx[7:3] + fcol;
    return {2'b11, map_hi, y[7:3], col};
  endfunction

  // Tile row address; signed mode flips the top bit by the index sign.
  function automatic logic [12:0] tile_addr(input logic unsigned_mode, input logic [7:0] idx,
                                            input logic [2:0] fy, input logic hi);
    logic top;
    top = unsigned_mode ? 1'b0 : ~idx[7];
    return {top, idx, fy, hi};
  endfunction

  // Element 0 is the leftmost pixel of the row.
  function automatic row_t row_pixels(input logic [7:0] lo, input logic [7:0] hi);
    row_t r;
    for (int c = 0; c < ROW_PX; c++) r[c] = {hi[7-c], lo[7-c]};
    return r;
  endfunction
endpackage

// File: rtl/tsr_timing.sv
module tsr_timing
  import tsr_pkg::*;
#(
  parameter int VIS_H       = 144,
  parameter int FRAME_LINES = 154,
  parameter int LINE_DOTS   = 456,
  parameter int SEARCH_DOTS = 80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pix_last,
  output logic [7:0] ly,
  output mode_t      mode
);
  localparam int DOT_W = $clog2(LINE_DOTS);
  localparam logic [DOT_W-1:0] DOT_LAST   = DOT_W'(LINE_DOTS - 1);
  localparam logic [DOT_W-1:0] DOT_SEARCH = DOT_W'(SEARCH_DOTS);
  localparam logic [7:0]       LY_LAST    = 8'(FRAME_LINES - 1);
  localparam logic [7:0]       LY_VIS     = 8'(VIS_H);

  logic [DOT_W-1:0] dot;
  logic             done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dot  <= '0;
      ly   <= '0;
      done <= 1'b0;
    end else if (dot == DOT_LAST) begin
      dot  <= '0;
      done <= 1'b0;
      ly   <= (ly == LY_LAST) ? 8'd0 : ly + 8'd1;
    end else begin
      dot <= dot + 1'b1;
      if (pix_last) done <= 1'b1;
    end
  end

  always_comb begin
    if (ly >= LY_VIS)          mode = MODE_VBLANK;
    else if (dot < DOT_SEARCH) mode = MODE_SEARCH;
    else if (!done)            mode = MODE_XFER;
    else                       mode = MODE_HBLANK;
  end
endmodule

// File: rtl/tsr_fetch.sv
module tsr_fetch
  import tsr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic [7:0]  ly,
  input  logic [7:0]  scx,
  input  logic [7:0]  scy,
  input  logic        map_hi,
  input  logic        tile_unsigned,
  input  logic [7:0]  rdata,
  input  logic        room,
  output logic [12:0] addr,
  output logic        rd,
  output logic        push,
  output logic        step_start,
  output row_t        row
);
  fstate_t    st;
  logic [4:0] fcol;
  logic [7:0] idx, lo, hi;
  logic [7:0] yline;

  assign yline = ly + scy;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      st   <= FS_IDX0;
      fcol <= '0;
    end else begin
      case (st)
        FS_IDX0: st <= FS_IDX1;
        FS_IDX1: begin idx <= rdata; st <= FS_LO0; end
        FS_LO0:  st <= FS_LO1;
        FS_LO1:  begin lo <= rdata; st <= FS_HI0; end
        FS_HI0:  st <= FS_HI1;
        FS_HI1:  begin hi <= rdata; st <= FS_PUSH; end
        FS_PUSH: if (room) begin fcol <= fcol + 5'd1; st <= FS_IDX0; end
        default: st <= FS_IDX0;
      endcase
    end
  end

  always_comb begin
    case (st)
      FS_IDX0, FS_IDX1: addr = map_addr(map_hi, ly, scy, scx, fcol);
      FS_LO0, FS_LO1:   addr = tile_addr(tile_unsigned, idx, yline[2:0], 1'b0);
      default:          addr = tile_addr(tile_unsigned, idx, yline[2:0], 1'b1);
    endcase
  end

  assign rd         = !clr && (st != FS_PUSH);
  assign step_start = !clr && (st == FS_IDX0 || st == FS_LO0 || st == FS_HI0);
  assign push       = !clr && (st == FS_PUSH) && room;
  assign row        = row_pixels(lo, hi);
endmodule

// File: rtl/tsr_fifo.sv
module tsr_fifo
  import tsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  row_t             row,
  input  logic             pop,
  output logic [1:0]       head,
  output logic [CNT_W-1:0] cnt
);
  logic [1:0] q    [FIFO_DEPTH];
  logic [1:0] q_nx [FIFO_DEPTH];
  logic [1:0] shift_in [FIFO_DEPTH];

  for (genvar k = 0; k < FIFO_DEPTH; k++) begin : g_slot
    if (k < FIFO_DEPTH - 1) begin : g_mid
      assign shift_in[k] = q[k+1];
    end else begin : g_end
      assign shift_in[k] = 2'b00;
    end
  end

  always_comb begin
    for (int k = 0; k < FIFO_DEPTH; k++) begin
      q_nx[k] = q[k];
      if (clr) q_nx[k] = 2'b00;
      else if (push) begin
        if (k >= int'(cnt) && k < int'(cnt) + ROW_PX) q_nx[k] = row[3'(k - int'(cnt))];
      end else if (pop) q_nx[k] = shift_in[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int k = 0; k < FIFO_DEPTH; k++) q[k] <= 2'b00;
    end else begin
      for (int k = 0; k < FIFO_DEPTH; k++) q[k] <= q_nx[k];
      if (clr)       cnt <= '0;
      else if (push) cnt <= cnt + CNT_W'(ROW_PX);
      else if (pop)  cnt <= cnt - 1'b1;
    end
  end

  assign head = q[0];
endmodule

// File: rtl/tile_scan_renderer.sv
module tile_scan_renderer
  import tsr_pkg::*;
#(
  parameter int VIS_W       = 160,
  parameter int VIS_H       = 144,
  parameter int FRAME_LINES = 154,
  parameter int LINE_DOTS   = 456,
  parameter int SEARCH_DOTS = 80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  scx,
  input  logic [7:0]  scy,
  input  logic        map_hi,
  input  logic        tile_unsigned,
  input  logic [7:0]  vram_rdata,
  output logic [12:0] vram_addr,
  output logic        vram_rd,
  output logic [1:0]  pix_data,
  output logic        pix_valid,
  output logic [7:0]  line,
  output logic [1:0]  mode
);
  localparam int X_W = $clog2(VIS_W + 1);
  localparam logic [X_W-1:0]   X_LAST = X_W'(VIS_W - 1);
  localparam logic [CNT_W-1:0] HALF   = CNT_W'(ROW_PX);

  mode_t            mode_q;
  logic             in_xfer, clr;
  logic [CNT_W-1:0] fifo_cnt;
  logic             fifo_room, push_fire, pop_fire, step_start, pix_last;
  logic [1:0]       head;
  row_t             row;
  logic [X_W-1:0]   x;
  logic [2:0]       disc;

  assign in_xfer   = (mode_q == MODE_XFER);
  assign clr       = !in_xfer;
  assign fifo_room = (fifo_cnt <= HALF);
  assign pop_fire  = in_xfer && (fifo_cnt > HALF);
  assign pix_last  = pop_fire && (disc == 3'd0) && (x == X_LAST);

  tsr_timing #(
    .VIS_H(VIS_H), .FRAME_LINES(FRAME_LINES),
    .LINE_DOTS(LINE_DOTS), .SEARCH_DOTS(SEARCH_DOTS)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .pix_last(pix_last), .ly(line), .mode(mode_q)
  );

  tsr_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ly(line), .scx(scx), .scy(scy),
    .map_hi(map_hi), .tile_unsigned(tile_unsigned), .rdata(vram_rdata),
    .room(fifo_room), .addr(vram_addr), .rd(vram_rd), .push(push_fire),
    .step_start(step_start), .row(row)
  );

  tsr_fifo u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push(push_fire), .row(row),
    .pop(pop_fire), .head(head), .cnt(fifo_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x         <= '0;
      disc      <= '0;
      pix_valid <= 1'b0;
      pix_data  <= 2'b00;
    end else begin
      pix_valid <= 1'b0;
      if (!in_xfer) begin
        x    <= '0;
        disc <= scx[2:0];
      end else if (pop_fire) begin
        if (disc != 3'd0) disc <= disc - 3'd1;
        else begin
          pix_valid <= 1'b1;
          pix_data  <= head;
          x         <= x + 1'b1;
        end
      end
    end
  end

  assign mode = mode_q;
endmodule

// File: rtl/tsr_checker.sv
module tsr_checker
  import tsr_pkg::*;
#(
  parameter int VIS_H = 144
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic [7:0]       line,
  input logic             vram_rd,
  input logic [12:0]      vram_addr,
  input logic             pix_valid,
  input logic [CNT_W-1:0] fifo_cnt,
  input logic             push_fire,
  input logic             pop_fire,
  input logic             step_start,
  input logic             pix_last
);
  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(FIFO_DEPTH)); // R8
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> fifo_cnt == $past(fifo_cnt) + CNT_W'(ROW_PX)); // R8
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> fifo_cnt == $past(fifo_cnt) - 1'b1); // R8
  AST_NO_PUSH_POP: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_fire && pop_fire)); // R8
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step_start && !pix_last) |=> (vram_rd && $stable(vram_addr))); // R8
  AST_RD_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    vram_rd |-> mode == 2'd3); // R9
  AST_VALID_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> line < 8'(VIS_H)); // R3
  AST_HBLANK_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd0 |=> mode != 2'd3); // R1
  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (line != $past(line)) |-> ($past(mode) == 2'd0 || $past(mode) == 2'd1)); // R2
endmodule

bind tile_scan_renderer tsr_checker #(.VIS_H(VIS_H)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .line(line), .vram_rd(vram_rd),
  .vram_addr(vram_addr), .pix_valid(pix_valid), .fifo_cnt(fifo_cnt),
  .push_fire(push_fire), .pop_fire(pop_fire), .step_start(step_start),
  .pix_last(pix_last)
);

// File: tb/tb_tile_scan_renderer.sv
module tb_tile_scan_renderer;
  localparam int W  = 48;
  localparam int H  = 20;
  localparam int LN = 24;
  localparam int DT = 200;
  localparam int SR = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  scx = 8'd0, scy = 8'd0;
  logic        map_hi = 1'b0, tile_unsigned = 1'b1;
  logic [7:0]  vram_rdata;
  logic [12:0] vram_addr;
  logic        vram_rd, pix_valid;
  logic [1:0]  pix_data, mode;
  logic [7:0]  line;
  logic [7:0]  mem [8192];

  int total = 0, fails = 0;
  int bdot = 0, bline = 0;
  int npx = 0, mism = 0, first_dot = -1, rd_bad = 0, vb_px = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  assign vram_rdata = mem[vram_addr];

  tile_scan_renderer #(
    .VIS_W(W), .VIS_H(H), .FRAME_LINES(LN), .LINE_DOTS(DT), .SEARCH_DOTS(SR)
  ) dut (
    .clk(clk), .rst_n(rst_n), .scx(scx), .scy(scy), .map_hi(map_hi),
    .tile_unsigned(tile_unsigned), .vram_rdata(vram_rdata), .vram_addr(vram_addr),
    .vram_rd(vram_rd), .pix_data(pix_data), .pix_valid(pix_valid),
    .line(line), .mode(mode)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (line %0d)", req, what, act, exp, bline);
    end
  endtask

  // Pixel from screen position: scrolled coordinates, then map, then tile bytes.
  function automatic int exp_px(input int ly, input int x);
    int y, bx, ma, idx, ta, b;
    logic [7:0] lo, hi;
    y   = (ly + int'(scy)) % 256;
    bx  = (x + int'(scx)) % 256;
    ma  = (map_hi ? 'h1C00 : 'h1800) + (y / 8) * 32 + bx / 8;
    idx = int'(mem[ma]);
    if (tile_unsigned) ta = idx * 16;
    else ta = 'h1000 + ((idx >= 128) ? idx - 256 : idx) * 16;
    ta  = ta + (y % 8) * 2;
    lo  = mem[ta];
    hi  = mem[ta + 1];
    b   = 7 - (bx % 8);
    return {hi[b], lo[b]};
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      bdot = 0; bline = 0;
    end else if (!finished) begin
      bdot++;
      if (bdot == DT) begin
        bdot = 0;
        bline = (bline == LN - 1) ? 0 : bline + 1;
      end
      if (bdot == 0) begin npx = 0; mism = 0; first_dot = -1; rd_bad = 0; vb_px = 0; end
      if (vram_rd && mode != 2'd3) rd_bad++;
      if (pix_valid) begin
        if (bline >= H) vb_px++;
        else begin
          if (first_dot < 0) first_dot = bdot;
          if (npx < W && int'(pix_data) != exp_px(bline, npx)) begin
            if (mism == 0)
              $display("FAIL R4 R5 R6 R7 pixel x=%0d: actual %0d expected %0d (line %0d)",
                       npx, pix_data, exp_px(bline, npx), bline);
            mism++;
          end
          npx++;
        end
      end
      if (bline < H) begin
        if (bdot == 0) begin
          chk(mode == 2'd2, "R1", "mode at line start", mode, 2);
          chk(int'(line) == bline, "R2", "line counter", line, bline);
        end
        if (bdot == SR) chk(mode == 2'd3, "R1", "mode at transfer start", mode, 3);
        if (bdot == DT - 1) begin
          chk(mode == 2'd0, "R1", "mode at line end", mode, 0);
          chk(npx == W, "R3", "pixels per line", npx, W);
          total++; if (mism != 0) fails++;   // R4 R5 R6 R7 pixel contents, FAIL printed above
          chk(first_dot == SR + 15 + int'(scx[2:0]), "R7 R8", "first pixel dot",
              first_dot, SR + 15 + int'(scx[2:0]));
          chk(rd_bad == 0, "R9", "reads outside transfer", rd_bad, 0);
        end
      end else if (bdot == DT - 1) begin
        chk(mode == 2'd1, "R2", "blank line mode", mode, 1);
        chk(int'(line) == bline, "R2", "blank line counter", line, bline);
        chk(vb_px == 0, "R3", "pixels on blank line", vb_px, 0);
        chk(rd_bad == 0, "R9", "reads on blank line", rd_bad, 0);
      end
    end
  end

  task automatic wait_line(input int n);
    do @(negedge clk); while (!(bline == n && bdot == 0));
  endtask

  task automatic set_regs(input int sx, input int sy, input bit mh, input bit tu);
    #1;
    scx = 8'(sx); scy = 8'(sy); map_hi = mh; tile_unsigned = tu;
  endtask

  initial begin
    void'($urandom(32'h1D2C_3B4A));
    for (int a = 0; a < 8192; a++) mem[a] = 8'($urandom);
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(mode == 2'd2, "R10", "reset mode", mode, 2);
    chk(line == 8'd0, "R10", "reset line", line, 0);
    chk(pix_valid == 1'b0, "R10", "reset pix_valid", pix_valid, 0);
    chk(vram_rd == 1'b0, "R10", "reset vram_rd", vram_rd, 0);
    #1 rst_n = 1'b1;
    wait_line(H);                       // frame 0: no scroll, unsigned tiles
    set_regs(7, 0, 1'b0, 1'b1);         wait_line(H);   // R7 maximum drop
    set_regs(3, 250, 1'b1, 1'b0);       wait_line(H);   // R5 R6 vertical wrap, signed
    set_regs(255, 13, 1'b0, 1'b0);      wait_line(H);   // R5 horizontal wrap
    for (int f = 0; f < 4; f++) begin
      set_regs(int'($urandom % 256), int'($urandom % 256), 1'($urandom), 1'($urandom));
      wait_line(H);
    end
    wait_line(0);                       // wrap from last blank line back to 0 (R2)
    chk(mode == 2'd2, "R2", "mode after frame wrap", mode, 2);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", total, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      total++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", total, fails);
      $finish;
    end
  end
endmodule